// File: doc/BRIEF.md
# I2C Slave Register-File Interface

This block is an I2C target that exposes a small bank of byte registers to a bus master. It oversamples the two bus lines with a fast system clock, recognises START, repeated START and STOP, compares the 7-bit device address, and acknowledges the bytes it accepts. The SDA output is an open-drain pull-down enable. The external pad drives the line low while the enable is high and releases it otherwise.

In a write transfer, the first byte after the address loads an internal register pointer. Every later byte is stored at the pointer, and the pointer then moves on by one. A read transfer returns bytes starting at the stored pointer and advances it the same way. A random read is a pointer-setting write, then a repeated START, then a read. A read that sends no pointer byte continues from wherever the pointer was left. A power-fail input blocks register access while it is asserted. Clock stretching and 10-bit addressing are not provided.

The control state machine has ten states:
- IDLE: waiting for a START.
- ADDR: shifting in the address byte.
- ADDR_ACK: acknowledging the address.
- PTR: shifting in the pointer byte.
- PTR_ACK: acknowledging the pointer byte.
- WDATA: shifting in a write byte.
- WDATA_ACK: acknowledging a write byte.
- RDATA: shifting out a read byte.
- RACK: sampling the master's acknowledge.
- WAIT: released, waiting for the bus to end the transfer.

Transitions:
- A START moves any state to ADDR.
- A STOP moves any state to IDLE.
- ADDR goes to ADDR_ACK on a matching address with power good, and to IDLE otherwise.
- ADDR_ACK goes to RDATA for a read and to PTR for a write.
- PTR goes to PTR_ACK when the pointer is in range with power good, and to IDLE otherwise.
- PTR_ACK goes to WDATA.
- WDATA goes to WDATA_ACK with power good, and to IDLE otherwise.
- WDATA_ACK goes back to WDATA.
- RDATA goes to RACK after eight bits.
- RACK goes to RDATA on a master ACK and to WAIT on a master NACK.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset `sda_oe` is 0. A START (SDA falling while SCL is high, repeated START included) begins a new address phase from any state. A STOP (SDA rising while SCL is high) returns the block to IDLE.
- R2: Only the 7-bit address 7'h68 is acknowledged, sent as byte 0xD0 for a write and 0xD1 for a read (bit 0 is the direction, 1 = read). Any other address is not acknowledged, and every later byte is ignored until the next START.
- R3: A pointer byte below 0x11 is acknowledged and loads the pointer. A pointer byte of 0x11 or more is not acknowledged and leaves the stored pointer unchanged.
- R4: Each acknowledged write byte is stored at the pointer, and the pointer then increments, wrapping from 0x10 to 0x00.
- R5: A read returns the byte at the pointer MSB first, and the pointer then increments with the same wrap. A read without a pointer byte continues from the stored pointer.
- R6: A pointer write followed by a repeated START and a read address returns data starting at the newly written pointer.
- R7: After the master NACKs a read byte, the block keeps SDA released until the next START or STOP. The pointer then sits one past the last byte sent.
- R8: While `pwr_fail_i` is 1, the address byte is not acknowledged. A write byte is not acknowledged and not stored. A read byte whose load happens while it is 1 is not driven, so it reads as 0xFF.
- R9: The acknowledge is driven low only for the 9th SCL clock, and SDA is released after that clock's falling edge. `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| pwr_fail_i | input | 1 | 1 blocks register access |

## Verification
Writes are tried with a run of distinct bytes at a mid-map pointer and with a run that crosses the top of the map. Reading them back with a random read and with a current-address read shows whether the pointer is stored, advanced and wrapped correctly. Foreign addresses, an out-of-range pointer and a power-fail assertion are each followed by a read whose expected value would differ if the ignored byte had moved the pointer or reached a register. An extra clocked byte after a master NACK shows whether SDA stays released.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } rf_state_e;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] pipe_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= line_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '1;
                else        pipe_q <= {pipe_q[STAGES-2:0], line_i};
            end
        end
    endgenerate

    // previous synchronized sample for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= pipe_q[STAGES-1];
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~pipe_q[STAGES-1] & prev_q;

endmodule

// File: rtl/i2c_rf_regs.sv
module i2c_rf_regs #(
    parameter int NUM_REGS = 17,
    parameter int DATA_W   = 8,
    parameter int PTR_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs_q[g] <= '0;
                else if (wr_en && (wr_addr == PTR_W'(g)))
                    regs_q[g] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = regs_q[rd_addr];

endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NUM_REGS    = 17,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic pwr_fail_i
);

    localparam int                PTR_W    = $clog2(NUM_REGS);
    localparam int                CNT_W    = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W);
    localparam logic [PTR_W-1:0]  PTR_MAX  = PTR_W'(NUM_REGS - 1);

    // synchronized bus samples and edges
    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start_evt, stop_evt;

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_i),
        .level_o(scl_s),
        .rise_o (scl_rise),
        .fall_o (scl_fall)
    );

    i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sda_i),
        .level_o(sda_s),
        .rise_o (sda_rise),
        .fall_o (sda_fall)
    );

    assign start_evt = sda_fall & scl_s;
    assign stop_evt  = sda_rise & scl_s;

    // state and datapath registers
    rf_state_e          state_q, nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [DATA_W-1:0]  rx_q;
    logic [DATA_W-1:0]  tx_q;
    logic               tx_en;
    logic               rw_q;
    logic               m_nack;
    logic [PTR_W-1:0]   ptr_q;
    logic [PTR_W-1:0]   ptr_inc;
    logic [DATA_W-1:0]  rd_data;

    logic byte_done, addr_hit, ptr_ok, wr_en, load_tx;

    assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
    assign addr_hit  = (rx_q[DATA_W-1 -: 7] == DEV_ADDR) && !pwr_fail_i;
    assign ptr_ok    = (rx_q < DATA_W'(NUM_REGS)) && !pwr_fail_i;
    assign wr_en     = (state_q == ST_WDATA) && byte_done && !pwr_fail_i;
    assign ptr_inc   = (ptr_q == PTR_MAX) ? '0 : ptr_q + 1'b1;
    assign load_tx   = ((state_q == ST_ADDR_ACK) && scl_fall && rw_q) ||
                       ((state_q == ST_RACK) && scl_fall && !m_nack);

    i2c_rf_regs #(
        .NUM_REGS(NUM_REGS),
        .DATA_W  (DATA_W),
        .PTR_W   (PTR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(ptr_q),
        .wr_data(rx_q),
        .rd_addr(ptr_q),
        .rd_data(rd_data)
    );

    // next-state logic
    always_comb begin
        nxt = state_q;
        if (start_evt) begin
            nxt = ST_ADDR;
        end else if (stop_evt) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall)  nxt = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) nxt = ptr_ok ? ST_PTR_ACK : ST_IDLE;
                ST_PTR_ACK:   if (scl_fall)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = pwr_fail_i ? ST_IDLE : ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && (bit_cnt == LAST_BIT - 1'b1)) nxt = ST_RACK;
                ST_RACK:      if (scl_fall)  nxt = m_nack ? ST_WAIT : ST_RDATA;
                ST_WAIT:      nxt = ST_WAIT;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // datapath: shift registers, bit counter, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            tx_en   <= 1'b0;
            rw_q    <= 1'b0;
            m_nack  <= 1'b1;
            ptr_q   <= '0;
        end else if (start_evt) begin
            bit_cnt <= '0;
        end else begin
            case (state_q)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && (bit_cnt != LAST_BIT)) begin
                        rx_q    <= {rx_q[DATA_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (state_q == ST_ADDR)          rw_q  <= rx_q[0];
                        if (state_q == ST_PTR && ptr_ok) ptr_q <= rx_q[PTR_W-1:0];
                        if (wr_en)                       ptr_q <= ptr_inc;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT - 1'b1) begin
                            bit_cnt <= '0;
                        end else begin
                            tx_q    <= tx_q << 1;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) m_nack <= sda_s;
                end
                default: ;
            endcase
            if (load_tx) begin
                tx_q    <= rd_data;
                tx_en   <= !pwr_fail_i;
                ptr_q   <= ptr_inc;
                bit_cnt <= '0;
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = tx_en && !tx_q[DATA_W-1];
            default:                               sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_rf_checker.sv
module i2c_rf_checker
    import i2c_rf_pkg::*;
#(
    parameter int NUM_REGS = 17,
    parameter int PTR_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input logic             start_evt,
    input logic             stop_evt,
    input rf_state_e        state_q,
    input logic             wr_en,
    input logic [PTR_W-1:0] ptr_q
);

    // R9: the pull-down only changes while the clock line is low
    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);

    // R1: a START always opens an address phase
    assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state_q == ST_ADDR));

    // R1: a STOP always returns to idle
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !start_evt) |=> (state_q == ST_IDLE));

    // R2: the line is released while idle
    assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

    // R7: the line is released while waiting after a master NACK
    assert_wait_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !sda_oe);

    // R3: the pointer never leaves the register map
    assert_ptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < PTR_W'(NUM_REGS));

    // R4: every stored byte moves the pointer on
    assert_write_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr_q != $past(ptr_q)));

endmodule

bind i2c_regfile_slave i2c_rf_checker #(
    .NUM_REGS(NUM_REGS),
    .PTR_W   (PTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .start_evt(start_evt),
    .stop_evt (stop_evt),
    .state_q  (state_q),
    .wr_en    (wr_en),
    .ptr_q    (ptr_q)
);

// File: tb/i2c_regfile_slave_tb_top.sv
module i2c_regfile_slave_tb_top;

    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe;
    logic sda_line;

    always #2.5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    i2c_regfile_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .pwr_fail_i(pwr_fail)
    );

    // scoreboard
    int    exp_q[$];
    string tag_q[$];
    int    obs_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    logic [7:0] mdl [17];
    int    mptr = 0;

    always @(negedge clk) begin
        while (obs_q.size() > 0) begin
            int    act;
            int    exv;
            string tg;
            act = obs_q.pop_front();
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected result: actual %0h expected none", act);
            end else begin
                exv = exp_q.pop_front();
                tg  = tag_q.pop_front();
                if (act != exv) begin
                    errors++;
                    $display("FAIL %s: actual %0h expected %0h", tg, act, exv);
                end
            end
        end
    end

    task automatic expect_val(input string tg, input int v);
        exp_q.push_back(v);
        tag_q.push_back(tg);
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait();
        scl = 1'b1;     qwait();
        sda_drv = 1'b0; qwait();
        scl = 1'b0;     qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl = 1'b1;     qwait();
        sda_drv = 1'b1; qwait();
    endtask

    // sends a byte, records 1 for ACK and 0 for NACK
    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i]; qwait();
            scl = 1'b1;     qwait(); qwait();
            scl = 1'b0;     qwait();
        end
        sda_drv = 1'b1; qwait();
        scl = 1'b1;     qwait();
        obs_q.push_back(sda_line ? 0 : 1);
        qwait();
        scl = 1'b0;     qwait();
    endtask

    // receives a byte and answers with ACK (nack=0) or NACK (nack=1)
    task automatic recv_byte(input bit nack);
        logic [7:0] v;
        v = '0;
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl = 1'b1; qwait();
            v[i] = sda_line;
            qwait();
            scl = 1'b0;
        end
        qwait();
        sda_drv = nack; qwait();
        scl = 1'b1;     qwait(); qwait();
        scl = 1'b0;     qwait();
        sda_drv = 1'b1;
        obs_q.push_back(int'(v));
    endtask

    task automatic model_read(input string tg, input bit nack);
        expect_val(tg, int'(mdl[mptr]));
        recv_byte(nack);
        mptr = (mptr == 16) ? 0 : mptr + 1;
    endtask

    task automatic model_write(input string tg, input logic [7:0] v);
        expect_val(tg, 1);
        send_byte(v);
        mdl[mptr] = v;
        mptr = (mptr == 16) ? 0 : mptr + 1;
    endtask

    task automatic finish_run();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 17; i++) mdl[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        expect_val("R1 sda released after reset", 0);
        obs_q.push_back(int'(sda_oe));

        // R5 current-address read straight after reset
        bus_start();
        expect_val("R2 read address ack", 1); send_byte(8'hD1);
        model_read("R5 current read after reset", 1'b1);
        bus_stop();

        // R3/R4 burst write from pointer 0x05
        bus_start();
        expect_val("R2 write address ack", 1); send_byte(8'hD0);
        expect_val("R3 pointer ack", 1); send_byte(8'h05); mptr = 5;
        model_write("R4 write ack 0", 8'hA5);
        model_write("R4 write ack 1", 8'h5A);
        model_write("R4 write ack 2", 8'hC3);
        model_write("R4 write ack 3", 8'h3C);
        expect_val("R9 sda released after ack clock", 0);
        obs_q.push_back(int'(sda_oe));
        bus_stop();

        // R6 random read with repeated START, then R7 release after NACK
        bus_start();
        expect_val("R2 write address ack", 1); send_byte(8'hD0);
        expect_val("R3 pointer ack", 1); send_byte(8'h05); mptr = 5;
        bus_start();
        expect_val("R6 read address ack after Sr", 1); send_byte(8'hD1);
        model_read("R6 first byte at new pointer", 1'b0);
        model_read("R5 auto-increment read", 1'b1);
        expect_val("R7 line released after NACK", 8'hFF); recv_byte(1'b1);
        bus_stop();

        // R2 foreign addresses are ignored
        bus_start();
        expect_val("R2 foreign address nack", 0); send_byte(8'hA0);
        expect_val("R2 byte after foreign address ignored", 0); send_byte(8'h00);
        bus_stop();
        bus_start();
        expect_val("R2 neighbour address nack", 0); send_byte(8'hD2);
        bus_stop();

        // R3 out-of-range pointer
        bus_start();
        expect_val("R2 write address ack", 1); send_byte(8'hD0);
        expect_val("R3 pointer 0x11 nack", 0); send_byte(8'h11);
        bus_stop();

        // R3 pointer unchanged; R5/R7 pointer sits one past last byte
        bus_start();
        expect_val("R2 read address ack", 1); send_byte(8'hD1);
        model_read("R3 pointer kept after bad pointer", 1'b0);
        model_read("R5 current read continues", 1'b1);
        bus_stop();

        // R4 wrap from 0x10 to 0x00
        bus_start();
        expect_val("R2 write address ack", 1); send_byte(8'hD0);
        expect_val("R3 pointer 0x10 ack", 1); send_byte(8'h10); mptr = 16;
        model_write("R4 write at top", 8'hE1);
        model_write("R4 write after wrap", 8'hE2);
        bus_stop();
        bus_start();
        expect_val("R2 write address ack", 1); send_byte(8'hD0);
        expect_val("R3 pointer 0x10 ack", 1); send_byte(8'h10); mptr = 16;
        bus_start();
        expect_val("R6 read address ack after Sr", 1); send_byte(8'hD1);
        model_read("R4 readback top register", 1'b0);
        model_read("R4 readback wrapped register", 1'b1);
        bus_stop();

        // R8 power fail blocks address
        pwr_fail = 1'b1;
        bus_start();
        expect_val("R8 address nack under power fail", 0); send_byte(8'hD0);
        bus_stop();
        pwr_fail = 1'b0;

        // R8 write byte blocked mid-transfer
        bus_start();
        expect_val("R2 write address ack", 1); send_byte(8'hD0);
        expect_val("R3 pointer ack", 1); send_byte(8'h02); mptr = 2;
        model_write("R4 write before power fail", 8'h11);
        pwr_fail = 1'b1;
        expect_val("R8 write byte nack under power fail", 0); send_byte(8'h22);
        bus_stop();
        pwr_fail = 1'b0;

        // R8 readback: blocked byte not stored, blocked read not driven
        bus_start();
        expect_val("R2 write address ack", 1); send_byte(8'hD0);
        expect_val("R3 pointer ack", 1); send_byte(8'h02); mptr = 2;
        bus_start();
        expect_val("R6 read address ack after Sr", 1); send_byte(8'hD1);
        model_read("R4 readback stored byte", 1'b0);
        pwr_fail = 1'b1;
        model_read("R8 blocked write not stored", 1'b0);
        expect_val("R8 read under power fail not driven", 8'hFF); recv_byte(1'b1);
        bus_stop();
        pwr_fail = 1'b0;

        done = 1'b1;
        finish_run();
    end

endmodule